// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block is the bypass network of a five-stage, 32-bit integer pipeline. It supplies the two ALU operands in the execute stage and the write-data word in the memory stage. An instruction can read a register whose new value has been computed but not yet written back. When that happens, the block replaces the stale register-file value with the newer result still held in the EX/MEM or MEM/WB pipeline register.

The second ALU operand can also be an immediate. The immediate is either sign-extended or zero-extended, as chosen by a 2-bit source code. A store in the memory stage can save a register that the instruction directly ahead of it, now in write-back, is about to update. In that case the write-data word is taken from the write-back value. The EX/MEM result is never used for store data.

The logic is purely combinational. It reads fields of the three pipeline registers and never modifies them. Stall detection, the ALU and the register file are outside the block.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage supplies a match, `alu_in1` equals `idex_rs_val`, and `alu_in2` with source code 0 equals `idex_rt_val`.
- R2: An operand whose register number equals `exmem_write_reg` while `exmem_reg_write` is 1 takes `exmem_alu_result`.
- R3: An operand whose register number equals `memwb_write_reg` while `memwb_reg_write` is 1, and which has no EX/MEM match, takes the write-back value.
- R4: When both EX/MEM and MEM/WB match the same operand, the EX/MEM result wins.
- R5: The write-back value is `memwb_mem_data` when `memwb_mem_to_reg` is 1, and `memwb_alu_result` otherwise.
- R6: Register number 0 is never forwarded. An operand naming register 0 passes its ID/EX value even when a stage writes register 0.
- R7: A stage with its register-write flag at 0 forwards nothing, whatever its destination number.
- R8: Source code 1 makes `alu_in2` the sign-extended `idex_imm16`. Code 2 makes it the zero-extended immediate. Code 3 makes it all zeros. Forwarding has no effect under codes 1 to 3.
- R9: With source code 0, `alu_in2` is forwarded from `idex_rt_num` under the same rules as `alu_in1` (R2 to R7).
- R10: `store_data` equals the write-back value when `exmem_mem_write` is 1, `memwb_reg_write` is 1 and `memwb_write_reg` equals a nonzero `exmem_rt_num`. Otherwise `store_data` equals `exmem_rt_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| idex_rs_num | input | 5 | First source register number in ID/EX |
| idex_rs_val | input | 32 | First source value read in decode |
| idex_rt_num | input | 5 | Second source register number in ID/EX |
| idex_rt_val | input | 32 | Second source value read in decode |
| idex_imm16 | input | 16 | Immediate field |
| idex_alu_src | input | 2 | Operand-2 source: 0 reg, 1 sign-ext, 2 zero-ext, 3 zero |
| exmem_reg_write | input | 1 | EX/MEM instruction writes a register |
| exmem_write_reg | input | 5 | EX/MEM destination register |
| exmem_alu_result | input | 32 | EX/MEM ALU result |
| exmem_mem_write | input | 1 | EX/MEM instruction is a store |
| exmem_rt_num | input | 5 | Register the store saves |
| exmem_rt_val | input | 32 | Store value carried from execute |
| memwb_reg_write | input | 1 | MEM/WB instruction writes a register |
| memwb_mem_to_reg | input | 1 | MEM/WB instruction is a load |
| memwb_write_reg | input | 5 | MEM/WB destination register |
| memwb_alu_result | input | 32 | MEM/WB ALU result |
| memwb_mem_data | input | 32 | MEM/WB loaded data |
| alu_in1 | output | 32 | ALU operand 1 |
| alu_in2 | output | 32 | ALU operand 2 |
| store_data | output | 32 | Memory write-data word |

## Verification
The assertions assume that all inputs are settled, two-valued levels whenever they are sampled. They also assume that the source code takes only the four defined values, and that register numbers stay within the 5-bit range. The bench drives every input to a definite value before each sample point. It draws register numbers from a narrow range of 0 to 3 so that stage matches, double matches and register-0 writes occur often. Directed cases reproduce the dependent instruction sequences: back-to-back use, use at distance two, load followed two cycles later by a use, and a store of the register written by the instruction just before it.

// File: rtl/fwd_pkg.sv
// Package: shared encodings for the operand forwarding unit.
// Assumes the operand-2 source code is 2 bits wide.
package fwd_pkg;

    // Operand-2 source selection codes
    typedef enum logic [1:0] {
        SRC_REG  = 2'd0,
        SRC_SIMM = 2'd1,
        SRC_ZIMM = 2'd2,
        SRC_ZERO = 2'd3
    } alu_src_e;

endpackage

// File: rtl/fwd_wb_value.sv
// Module: picks the value an instruction in write-back will commit.
// Assumes the load data and ALU result are both valid when sampled.
module fwd_wb_value #(
    parameter int XLEN = 32
) (
    input  logic            mem_to_reg,
    input  logic [XLEN-1:0] alu_result,
    input  logic [XLEN-1:0] mem_data,
    output logic [XLEN-1:0] wb_value
);

    // Load results come from memory, all others from the ALU
    always_comb begin
        wb_value = mem_to_reg ? mem_data : alu_result;
    end

endmodule

// File: rtl/fwd_source_sel.sv
// Module: resolves one source register against the two later stages.
// Assumes register 0 is hardwired to zero and is never a forwarding target.
module fwd_source_sel #(
    parameter int XLEN  = 32,
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_num,
    input  logic [XLEN-1:0]   stage_val,
    input  logic              exmem_reg_write,
    input  logic [REG_AW-1:0] exmem_write_reg,
    input  logic [XLEN-1:0]   exmem_value,
    input  logic              memwb_reg_write,
    input  logic [REG_AW-1:0] memwb_write_reg,
    input  logic [XLEN-1:0]   memwb_value,
    output logic [XLEN-1:0]   src_val
);

    logic src_nonzero;
    logic exmem_hit;
    logic memwb_hit;

    // Match detection for each producing stage
    always_comb begin
        src_nonzero = (src_num != '0);
        exmem_hit   = exmem_reg_write && (exmem_write_reg == src_num) && src_nonzero;
        memwb_hit   = memwb_reg_write && (memwb_write_reg == src_num) && src_nonzero;
    end

    // Priority select: newest producer first
    always_comb begin
        if (exmem_hit) begin
            src_val = exmem_value;
        end else if (memwb_hit) begin
            src_val = memwb_value;
        end else begin
            src_val = stage_val;
        end
    end

endmodule

// File: rtl/fwd_operand2.sv
// Module: final operand-2 select between forwarded register and immediates.
// Assumes IMM_W is less than XLEN.
module fwd_operand2 #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [1:0]       alu_src,
    input  logic [XLEN-1:0]  reg_val,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  operand
);

    import fwd_pkg::*;

    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_sext;
    logic [XLEN-1:0] imm_zext;

    // Both extensions of the immediate field
    always_comb begin
        imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
        imm_zext = {{EXT_W{1'b0}}, imm};
    end

    // Source code decode
    always_comb begin
        case (alu_src_e'(alu_src))
            SRC_REG:  operand = reg_val;
            SRC_SIMM: operand = imm_sext;
            SRC_ZIMM: operand = imm_zext;
            default:  operand = '0;
        endcase
    end

endmodule

// File: rtl/fwd_store_path.sv
// Module: memory write-data select for a store in the memory stage.
// Assumes only the write-back stage can bypass into the store port.
module fwd_store_path #(
    parameter int XLEN  = 32,
    parameter int REG_AW = 5
) (
    input  logic              mem_write,
    input  logic [REG_AW-1:0] rt_num,
    input  logic [XLEN-1:0]   rt_val,
    input  logic              memwb_reg_write,
    input  logic [REG_AW-1:0] memwb_write_reg,
    input  logic [XLEN-1:0]   memwb_value,
    output logic [XLEN-1:0]   wdata
);

    logic bypass;

    // Detect a store saving the register just produced ahead of it
    always_comb begin
        bypass = mem_write && memwb_reg_write &&
                 (memwb_write_reg == rt_num) && (rt_num != '0);
    end

    // Write-data mux
    always_comb begin
        wdata = bypass ? memwb_value : rt_val;
    end

endmodule

// File: rtl/fwd_unit.sv
// Module: top of the forwarding network for the EX and MEM stages.
// Assumes all inputs come straight from pipeline registers; purely combinational.
module fwd_unit #(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5,
    parameter int IMM_W  = 16
) (
    input  logic [REG_AW-1:0] idex_rs_num,
    input  logic [XLEN-1:0]   idex_rs_val,
    input  logic [REG_AW-1:0] idex_rt_num,
    input  logic [XLEN-1:0]   idex_rt_val,
    input  logic [IMM_W-1:0]  idex_imm16,
    input  logic [1:0]        idex_alu_src,
    input  logic              exmem_reg_write,
    input  logic [REG_AW-1:0] exmem_write_reg,
    input  logic [XLEN-1:0]   exmem_alu_result,
    input  logic              exmem_mem_write,
    input  logic [REG_AW-1:0] exmem_rt_num,
    input  logic [XLEN-1:0]   exmem_rt_val,
    input  logic              memwb_reg_write,
    input  logic              memwb_mem_to_reg,
    input  logic [REG_AW-1:0] memwb_write_reg,
    input  logic [XLEN-1:0]   memwb_alu_result,
    input  logic [XLEN-1:0]   memwb_mem_data,
    output logic [XLEN-1:0]   alu_in1,
    output logic [XLEN-1:0]   alu_in2,
    output logic [XLEN-1:0]   store_data
);

    localparam int NUM_SRC = 2;

    logic [XLEN-1:0]   wb_value;
    logic [REG_AW-1:0] src_num [NUM_SRC];
    logic [XLEN-1:0]   src_raw [NUM_SRC];
    logic [XLEN-1:0]   src_fwd [NUM_SRC];

    // Gather both source operands into indexed arrays
    always_comb begin
        src_num[0] = idex_rs_num;
        src_raw[0] = idex_rs_val;
        src_num[1] = idex_rt_num;
        src_raw[1] = idex_rt_val;
    end

    fwd_wb_value #(.XLEN(XLEN)) u_wb_value (
        .mem_to_reg (memwb_mem_to_reg),
        .alu_result (memwb_alu_result),
        .mem_data   (memwb_mem_data),
        .wb_value   (wb_value)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        fwd_source_sel #(.XLEN(XLEN), .REG_AW(REG_AW)) u_sel (
            .src_num         (src_num[g]),
            .stage_val       (src_raw[g]),
            .exmem_reg_write (exmem_reg_write),
            .exmem_write_reg (exmem_write_reg),
            .exmem_value     (exmem_alu_result),
            .memwb_reg_write (memwb_reg_write),
            .memwb_write_reg (memwb_write_reg),
            .memwb_value     (wb_value),
            .src_val         (src_fwd[g])
        );
    end

    fwd_operand2 #(.XLEN(XLEN), .IMM_W(IMM_W)) u_operand2 (
        .alu_src (idex_alu_src),
        .reg_val (src_fwd[1]),
        .imm     (idex_imm16),
        .operand (alu_in2)
    );

    fwd_store_path #(.XLEN(XLEN), .REG_AW(REG_AW)) u_store (
        .mem_write       (exmem_mem_write),
        .rt_num          (exmem_rt_num),
        .rt_val          (exmem_rt_val),
        .memwb_reg_write (memwb_reg_write),
        .memwb_write_reg (memwb_write_reg),
        .memwb_value     (wb_value),
        .wdata           (store_data)
    );

    // Operand 1 is always the forwarded first source
    always_comb begin
        alu_in1 = src_fwd[0];
    end

endmodule

// File: rtl/fwd_unit_checker.sv
// Module: property checks on the forwarding unit ports, bound into fwd_unit.
// Assumes inputs are settled two-valued levels whenever evaluated.
module fwd_unit_checker #(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5,
    parameter int IMM_W  = 16
) (
    input logic [REG_AW-1:0] idex_rs_num,
    input logic [XLEN-1:0]   idex_rs_val,
    input logic [IMM_W-1:0]  idex_imm16,
    input logic [1:0]        idex_alu_src,
    input logic              exmem_reg_write,
    input logic [REG_AW-1:0] exmem_write_reg,
    input logic [XLEN-1:0]   exmem_alu_result,
    input logic              exmem_mem_write,
    input logic [XLEN-1:0]   exmem_rt_val,
    input logic              memwb_reg_write,
    input logic [XLEN-1:0]   alu_in1,
    input logic [XLEN-1:0]   alu_in2,
    input logic [XLEN-1:0]   store_data
);

    // Port-level invariants of the bypass network
    always_comb begin
        if (idex_rs_num == '0) begin
            assert_zero_reg_R6: assert (alu_in1 == idex_rs_val);
        end
        if (!exmem_reg_write && !memwb_reg_write) begin
            assert_no_write_R7: assert (alu_in1 == idex_rs_val);
        end
        if (exmem_reg_write && exmem_write_reg == idex_rs_num && idex_rs_num != '0) begin
            assert_exmem_wins_R4: assert (alu_in1 == exmem_alu_result);
        end
        if (idex_alu_src == 2'd2) begin
            assert_zext_R8: assert (alu_in2 == {{(XLEN-IMM_W){1'b0}}, idex_imm16});
        end
        if (idex_alu_src == 2'd3) begin
            assert_zero_src_R8: assert (alu_in2 == '0);
        end
        if (!exmem_mem_write) begin
            assert_store_plain_R10: assert (store_data == exmem_rt_val);
        end
    end

endmodule

bind fwd_unit fwd_unit_checker #(.XLEN(XLEN), .REG_AW(REG_AW), .IMM_W(IMM_W)) u_fwd_unit_checker (.*);

// File: tb/fwd_unit_bench.sv
// Bench: directed pipeline sequences plus seeded random stimulus for fwd_unit.
module fwd_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_ITERS = 3000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [4:0]  rs_num, rt_num, ex_wr, ex_rtn, wb_wr;
    logic [31:0] rs_val, rt_val, ex_res, ex_rtv, wb_res, wb_mem;
    logic [15:0] imm;
    logic [1:0]  asrc;
    logic        ex_rw, ex_mw, wb_rw, wb_m2r;
    logic [31:0] alu_in1, alu_in2, store_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    fwd_unit u_fwd_unit (
        .idex_rs_num      (rs_num),
        .idex_rs_val      (rs_val),
        .idex_rt_num      (rt_num),
        .idex_rt_val      (rt_val),
        .idex_imm16       (imm),
        .idex_alu_src     (asrc),
        .exmem_reg_write  (ex_rw),
        .exmem_write_reg  (ex_wr),
        .exmem_alu_result (ex_res),
        .exmem_mem_write  (ex_mw),
        .exmem_rt_num     (ex_rtn),
        .exmem_rt_val     (ex_rtv),
        .memwb_reg_write  (wb_rw),
        .memwb_mem_to_reg (wb_m2r),
        .memwb_write_reg  (wb_wr),
        .memwb_alu_result (wb_res),
        .memwb_mem_data   (wb_mem),
        .alu_in1          (alu_in1),
        .alu_in2          (alu_in2),
        .store_data       (store_data)
    );

    // Reference model (R5): value committed by write-back
    function automatic logic [31:0] m_wb();
        return wb_m2r ? wb_mem : wb_res;
    endfunction

    // Reference model (R1-style rules R2, R3, R4, R6, R7)
    function automatic logic [31:0] m_src(input logic [4:0] n, input logic [31:0] v);
        if (n == 5'd0) return v;
        if (ex_rw && ex_wr == n) return ex_res;
        if (wb_rw && wb_wr == n) return m_wb();
        return v;
    endfunction

    // Reference model (R8, R9)
    function automatic logic [31:0] m_in2();
        case (asrc)
            2'd0: return m_src(rt_num, rt_val);
            2'd1: return {{16{imm[15]}}, imm};
            2'd2: return {16'h0000, imm};
            default: return 32'h0;
        endcase
    endfunction

    // Reference model (R10)
    function automatic logic [31:0] m_store();
        if (ex_mw && wb_rw && ex_rtn != 5'd0 && wb_wr == ex_rtn) return m_wb();
        return ex_rtv;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Sample all outputs away from the driving edge
    task automatic sample(input string tag);
        @(negedge clk);
        check(tag, "alu_in1", alu_in1, m_src(rs_num, rs_val));
        check(tag, "alu_in2", alu_in2, m_in2());
        check(tag, "store_data", store_data, m_store());
    endtask

    task automatic clear();
        @(posedge clk);
        rs_num = 0; rt_num = 0; ex_wr = 0; ex_rtn = 0; wb_wr = 0;
        rs_val = 0; rt_val = 0; ex_res = 0; ex_rtv = 0; wb_res = 0; wb_mem = 0;
        imm = 0; asrc = 0; ex_rw = 0; ex_mw = 0; wb_rw = 0; wb_m2r = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20210501));

        // Quiet state: all zero inputs give zero outputs (R1)
        clear();
        @(negedge clk);
        check("R1", "idle in1", alu_in1, 32'h0);
        check("R1", "idle in2", alu_in2, 32'h0);
        check("R1", "idle store", store_data, 32'h0);

        // No match: register values pass through (R1)
        clear();
        rs_num = 7; rs_val = 32'h1111_2222; rt_num = 8; rt_val = 32'h3333_4444;
        ex_rw = 1; ex_wr = 9; ex_res = 32'hDEAD_0001;
        sample("R1");
        check("R1", "in1 pass", alu_in1, 32'h1111_2222);

        // Back-to-back dependency on rs (R2)
        clear();
        rs_num = 3; rs_val = 32'h5; ex_rw = 1; ex_wr = 3; ex_res = 32'hA0A0_0003;
        sample("R2");
        check("R2", "in1 from EX/MEM", alu_in1, 32'hA0A0_0003);

        // Distance-two dependency on rt (R3, R9)
        clear();
        rt_num = 4; rt_val = 32'h6; wb_rw = 1; wb_wr = 4; wb_res = 32'hB0B0_0004;
        sample("R3");
        check("R9", "in2 from MEM/WB", alu_in2, 32'hB0B0_0004);

        // Both stages match: newer wins (R4)
        clear();
        rs_num = 5; rt_num = 5; ex_rw = 1; ex_wr = 5; ex_res = 32'hC0C0_0005;
        wb_rw = 1; wb_wr = 5; wb_res = 32'hD0D0_0005;
        sample("R4");
        check("R4", "in1 newest", alu_in1, 32'hC0C0_0005);
        check("R4", "in2 newest", alu_in2, 32'hC0C0_0005);

        // Load then use two cycles later (R5)
        clear();
        rs_num = 6; rs_val = 32'h1; wb_rw = 1; wb_m2r = 1; wb_wr = 6;
        wb_res = 32'h0000_1000; wb_mem = 32'hFEED_F00D;
        sample("R5");
        check("R5", "in1 load data", alu_in1, 32'hFEED_F00D);

        // Writes to register 0 are not forwarded (R6)
        clear();
        rs_num = 0; rs_val = 32'h0; rt_num = 0; rt_val = 32'h0;
        ex_rw = 1; ex_wr = 0; ex_res = 32'h1234_5678; wb_rw = 1; wb_wr = 0; wb_res = 32'h9;
        sample("R6");
        check("R6", "in1 reg0", alu_in1, 32'h0);

        // Matching numbers but write flags clear (R7)
        clear();
        rs_num = 2; rs_val = 32'h77; ex_wr = 2; ex_res = 32'h88; wb_wr = 2; wb_res = 32'h99;
        sample("R7");
        check("R7", "in1 no write", alu_in1, 32'h77);

        // Immediates ignore forwarding (R8)
        for (int c = 1; c < 4; c++) begin
            clear();
            rt_num = 4; rt_val = 32'h1; ex_rw = 1; ex_wr = 4; ex_res = 32'h2;
            imm = 16'h8001; asrc = 2'(c);
            sample("R8");
        end
        clear();
        imm = 16'h8001; asrc = 2'd1;
        @(negedge clk);
        check("R8", "sign ext", alu_in2, 32'hFFFF_8001);
        clear();
        imm = 16'h8001; asrc = 2'd2;
        @(negedge clk);
        check("R8", "zero ext", alu_in2, 32'h0000_8001);

        // Store data from the instruction just before the store (R10)
        clear();
        ex_mw = 1; ex_rtn = 9; ex_rtv = 32'h0BAD; wb_rw = 1; wb_wr = 9; wb_res = 32'h600D;
        ex_rw = 1; ex_wr = 9; ex_res = 32'hEEEE;
        sample("R10");
        check("R10", "store bypass", store_data, 32'h600D);
        clear();
        ex_mw = 0; ex_rtn = 9; ex_rtv = 32'h0BAD; wb_rw = 1; wb_wr = 9; wb_res = 32'h600D;
        sample("R10");
        check("R10", "no store", store_data, 32'h0BAD);

        // Random mix with narrow register numbers
        for (int i = 0; i < RAND_ITERS; i++) begin
            @(posedge clk);
            rs_num = 5'($urandom_range(0, 3)); rt_num = 5'($urandom_range(0, 3));
            ex_wr = 5'($urandom_range(0, 3)); wb_wr = 5'($urandom_range(0, 3));
            ex_rtn = 5'($urandom_range(0, 3));
            rs_val = $urandom; rt_val = $urandom; ex_res = $urandom; ex_rtv = $urandom;
            wb_res = $urandom; wb_mem = $urandom; imm = 16'($urandom);
            asrc = 2'($urandom_range(0, 3));
            ex_rw = 1'($urandom); ex_mw = 1'($urandom);
            wb_rw = 1'($urandom); wb_m2r = 1'($urandom);
            sample("R2/R3/R4/R5/R6/R7/R8/R9/R10");
        end

        summary();
    end

endmodule